// File: doc/BRIEF.md
# Mask-Driven Permute Control Generator

This block turns a 128-bit mask vector into a 128-bit permute control vector made of sixteen byte indices. A byte-permute unit further down the datapath uses that vector. It can spread packed source elements out into the positions the mask selects, which is expansion. It can also gather the selected elements into one contiguous run, which is compression. The caller picks an element size of one, two, four or eight bytes. The caller also picks a mode that sets the direction (expansion or compression) and whether bytes are numbered from the most significant end or the least significant end.

An element's select flag is the most significant bit of that element in the mask. All other mask bits are ignored. The block computes the control vector combinationally. The result is captured one cycle after an input strobe. The output valid strobe and an illegal-mode flag are captured in the same cycle. A mode code outside the four defined ones raises the flag and produces an all-zero vector.

Top module: `maskperm_ctl_gen`

## Requirements
- R1: The element size code `in_esize` selects 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3, giving 16, 8, 4 or 2 elements. An element is selected exactly when its most significant mask bit is 1. No other mask bit changes the result.
- R2: In modes 0 and 1 (left-numbered), byte position 0 is bits 127:120 and element 0 is the most significant element. In modes 2 and 3 (right-numbered), byte position 0 is bits 7:0 and element 0 is the least significant element. Control bytes are placed in the output using the same numbering as the mode.
- R3: Mode 0 expands with left numbering. Scan elements from element 0 upward with a count j that starts at 0. A selected element k gets control bytes j*size+b for byte b = 0..size-1, and j then increments. An unselected element k gets 0x10 + k*size + b.
- R4: Mode 1 compresses with left numbering. The n-th selected element k, counting from n = 0 in scan order, writes k*size+b into byte b of output slot n.
- R5: Mode 2 expands with right numbering. It follows the same rule as R3, and the fill for unselected positions is again 0x10 + k*size + b.
- R6: Mode 3 compresses with right numbering. It follows the same rule as R4, so the selected elements are packed into the least significant slots.
- R7: In modes 1 and 3, every output slot at or beyond the number of selected elements is driven to 0x00.
- R8: Mode codes 4 to 7 on `in_mode` are illegal. The flag `out_illegal` is then 1 and `out_pcv` is all zeros. Legal codes give `out_illegal` = 0.
- R9: `out_valid` is `in_valid` delayed by one clock. `out_pcv` and `out_illegal` are updated one clock after a cycle with `in_valid` high. After a cycle with `in_valid` low they hold their values, whatever the other inputs do.
- R10: While reset is asserted, `out_valid`, `out_illegal` and `out_pcv` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_mask | input | 128 | Mask vector; only element MSBs matter |
| in_esize | input | 2 | Element size code |
| in_mode | input | 3 | Mode code; 0 to 3 legal |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_pcv | output | 128 | Permute control vector |
| out_illegal | output | 1 | Illegal mode code was seen |

## Verification
The bench sweeps every select pattern for halfword, word and doubleword sizes, and a large random set for bytes. It runs every pattern in all eight mode codes. Random filler in the non-select bits catches a design that samples the wrong bit of an element. Such a design would make the wrong elements selected. Left and right numbering produce different vectors for the same mask, so mixing them up reverses byte order or picks the wrong select flags. A compression that leaves stale or expansion-style values in unused slots shows up as non-zero tail bytes. A fill index built from the running count instead of the position shows up as wrong fill bytes. The idle cycles at the end of the run show whether the output holds, or reacts to inputs given without a strobe.

// File: rtl/pcv_pkg.sv
`timescale 1ns/1ps
package pcv_pkg;

  typedef enum logic [2:0] {
    PCV_EXP_LEFT  = 3'd0,
    PCV_CMP_LEFT  = 3'd1,
    PCV_EXP_RIGHT = 3'd2,
    PCV_CMP_RIGHT = 3'd3
  } pcv_mode_e;

  function automatic logic mode_legal(input logic [2:0] m);
    return (m == PCV_EXP_LEFT) || (m == PCV_CMP_LEFT) ||
           (m == PCV_EXP_RIGHT) || (m == PCV_CMP_RIGHT);
  endfunction

  function automatic logic mode_right(input logic [2:0] m);
    return (m == PCV_EXP_RIGHT) || (m == PCV_CMP_RIGHT);
  endfunction

  function automatic logic mode_compress(input logic [2:0] m);
    return (m == PCV_CMP_LEFT) || (m == PCV_CMP_RIGHT);
  endfunction

endpackage

// File: rtl/pcv_select.sv
`timescale 1ns/1ps
// Extracts the per-element select flags (element MSB) in scan order.
module pcv_select #(
  parameter int NB = 16,
  parameter int BW = 8
) (
  input  logic [NB-1:0][BW-1:0] mask_b,
  input  logic [1:0]            esize,
  input  logic                  right,
  output logic [NB-1:0]         sel
);
  localparam int IW = $clog2(NB);
  localparam int CW = IW + 1;

  logic [IW-1:0] span;
  logic [CW-1:0] nel;

  assign span = ~({IW{1'b1}} << esize);
  assign nel  = CW'(NB) >> esize;

  for (genvar k = 0; k < NB; k++) begin : g_elem
    logic [IW-1:0] base;
    logic [IW-1:0] pick;
    assign base = IW'(k) << esize;
    // right numbering: top byte of the element counted from bit 0
    // left numbering: first byte of the element counted from bit 127
    assign pick = right ? (base | span) : (IW'(NB - 1) - base);
    assign sel[k] = (CW'(k) < nel) && mask_b[pick][BW-1];
  end

  logic unused_low_bits;
  always_comb begin
    unused_low_bits = 1'b0;
    for (int i = 0; i < NB; i++) unused_low_bits = unused_low_bits ^ (^mask_b[i][BW-2:0]);
  end

endmodule

// File: rtl/pcv_index_core.sv
`timescale 1ns/1ps
// Builds control bytes in scan-order (logical) byte numbering.
module pcv_index_core #(
  parameter int NB = 16,
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chk_en,
  input  logic [NB-1:0]         sel,
  input  logic [1:0]            esize,
  input  logic                  compress,
  output logic [NB-1:0][BW-1:0] ctl
);
  localparam int IW = $clog2(NB);
  localparam int CW = IW + 1;

  logic [CW-1:0] cnt [NB];
  logic [CW-1:0] total;
  logic [IW-1:0] bmask;

  always_comb begin : prefix
    logic [CW-1:0] acc;
    acc = '0;
    for (int k = 0; k < NB; k++) begin
      cnt[k] = acc;
      acc    = acc + {{(CW-1){1'b0}}, sel[k]};
    end
    total = acc;
  end

  assign bmask = ~({IW{1'b1}} << esize);

  for (genvar q = 0; q < NB; q++) begin : g_byte
    logic [IW-1:0] pos;
    logic [IW-1:0] slot;
    logic [IW-1:0] sub;
    logic [IW-1:0] expv;
    logic [IW-1:0] cmpv;

    assign pos  = IW'(q);
    assign slot = pos >> esize;
    assign sub  = pos & bmask;

    always_comb begin
      expv = (cnt[slot][IW-1:0] << esize) | sub;
      cmpv = '0;
      for (int k = 0; k < NB; k++) begin
        if (sel[k] && (cnt[k] == {1'b0, slot})) cmpv = cmpv | ((IW'(k) << esize) | sub);
      end
    end

    assign ctl[q] = compress    ? {{(BW-IW){1'b0}}, cmpv} :
                    sel[slot]   ? {{(BW-IW){1'b0}}, expv} :
                                  BW'(NB + q);

    // R3/R5: any index into the second operand is the position fill value
    p_fill_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !compress && (ctl[q] >= BW'(NB))) |-> (ctl[q] == BW'(NB + q)));

    // R4/R6: compression only ever references the first operand
    p_cmp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && compress) |-> (ctl[q] < BW'(NB)));

    // R7: slots past the selected count are zero
    p_zero_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && compress && ({1'b0, slot} >= total)) |-> (ctl[q] == '0));
  end

endmodule

// File: rtl/pcv_orient.sv
`timescale 1ns/1ps
// Maps logical byte q to its physical byte; right numbering is identity.
module pcv_orient #(
  parameter int NB = 16,
  parameter int BW = 8
) (
  input  logic                  right,
  input  logic [NB-1:0][BW-1:0] din,
  output logic [NB-1:0][BW-1:0] dout
);
  for (genvar q = 0; q < NB; q++) begin : g_map
    assign dout[q] = right ? din[q] : din[NB-1-q];
  end
endmodule

// File: rtl/maskperm_ctl_gen.sv
`timescale 1ns/1ps
module maskperm_ctl_gen
  import pcv_pkg::*;
#(
  parameter int NB = 16,
  parameter int BW = 8,
  localparam int VEC_W = NB * BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_mask,
  input  logic [1:0]       in_esize,
  input  logic [2:0]       in_mode,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_pcv,
  output logic             out_illegal
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic legal, right, compress;
  assign legal    = mode_legal(in_mode);
  assign right    = mode_right(in_mode);
  assign compress = mode_compress(in_mode);

  logic [NB-1:0][BW-1:0] mask_b, ctl_log, ctl_phys;
  logic [NB-1:0]         sel;

  assign mask_b = in_mask;

  pcv_select #(.NB(NB), .BW(BW)) u_select (
    .mask_b (mask_b),
    .esize  (in_esize),
    .right  (right),
    .sel    (sel)
  );

  pcv_index_core #(.NB(NB), .BW(BW)) u_core (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .chk_en   (in_valid && legal),
    .sel      (sel),
    .esize    (in_esize),
    .compress (compress),
    .ctl      (ctl_log)
  );

  pcv_orient #(.NB(NB), .BW(BW)) u_orient (
    .right (right),
    .din   (ctl_log),
    .dout  (ctl_phys)
  );

  logic             valid_q, valid_d;
  logic             illegal_q, illegal_d;
  logic [VEC_W-1:0] pcv_q, pcv_d;

  always_comb begin
    valid_d   = in_valid;
    illegal_d = illegal_q;
    pcv_d     = pcv_q;
    if (in_valid) begin
      illegal_d = !legal;
      pcv_d     = legal ? VEC_W'(ctl_phys) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      pcv_q     <= '0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) begin
        illegal_q <= illegal_d;
        pcv_q     <= pcv_d;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = illegal_q;
  assign out_pcv     = pcv_q;

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_valid && $stable(out_pcv) && $stable(out_illegal)));
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_mode[2]) |=> (out_illegal && (out_pcv == '0)));
  p_legal_flag_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !in_mode[2]) |=> !out_illegal);

endmodule

// File: tb/tb_maskperm_ctl_gen.sv
`timescale 1ns/1ps
module tb_maskperm_ctl_gen;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_mask;
  logic [1:0]   in_esize;
  logic [2:0]   in_mode;
  logic         out_valid;
  logic [127:0] out_pcv;
  logic         out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  maskperm_ctl_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mask(in_mask),
    .in_esize(in_esize), .in_mode(in_mode), .out_valid(out_valid),
    .out_pcv(out_pcv), .out_illegal(out_illegal)
  );

  function automatic logic [127:0] ref_pcv(logic [127:0] m, int es, int md);
    logic [127:0] res;
    int s, n, j, msb, p, lsb, val;
    bit right, cmp, sel;
    res = '0;
    if (md > 3) return res;
    s = 1 << es; n = 16 / s; j = 0;
    right = (md >= 2); cmp = (md % 2 == 1);
    for (int k = 0; k < n; k++) begin
      msb = right ? (k * s * 8 + s * 8 - 1) : (127 - k * s * 8);
      sel = m[msb];
      for (int b = 0; b < s; b++) begin
        if (!cmp) begin
          p = k * s + b;
          val = sel ? (j * s + b) : (16 + k * s + b);
        end else begin
          p = j * s + b;
          val = k * s + b;
        end
        if (!cmp || sel) begin
          lsb = right ? (8 * p) : (120 - 8 * p);
          res[lsb +: 8] = 8'(val);
        end
      end
      if (sel) j++;
    end
    return res;
  endfunction

  function automatic logic [127:0] build_mask(int es, logic [15:0] pat, logic [127:0] filler);
    logic [127:0] m;
    int s, n;
    m = filler; s = 1 << es; n = 16 / s;
    for (int k = 0; k < n; k++) m[k * s * 8 + s * 8 - 1] = pat[k];
    return m;
  endfunction

  function automatic string mode_tag(int md);
    case (md)
      0: return "R1 R2 R3 expand-left";
      1: return "R1 R2 R4 R7 compress-left";
      2: return "R1 R2 R5 expand-right";
      3: return "R1 R2 R6 R7 compress-right";
      default: return "R8 illegal zero vector";
    endcase
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(logic [127:0] m, int es, int md);
    logic [127:0] exp;
    in_mask = m; in_esize = 2'(es); in_mode = 3'(md); in_valid = 1'b1;
    exp = ref_pcv(m, es, md);
    @(negedge clk);
    chk($sformatf("%s es=%0d", mode_tag(md), es), out_pcv, exp);
    chk("R8 illegal flag", {127'b0, out_illegal}, {127'b0, (md > 3)});
    chk("R9 out_valid", {127'b0, out_valid}, 128'd1);
  endtask

  task automatic sweep_one(int es, logic [15:0] pat);
    logic [127:0] m;
    m = build_mask(es, pat, rnd128());
    for (int md = 0; md < 8; md++) txn(m, es, md);
  endtask

  initial begin
    logic [127:0] last;
    rst_n = 1'b0; in_valid = 1'b0; in_mask = '0; in_esize = '0; in_mode = '0;
    repeat (4) @(negedge clk);
    chk("R10 reset out_valid", {127'b0, out_valid}, '0);
    chk("R10 reset out_illegal", {127'b0, out_illegal}, '0);
    chk("R10 reset out_pcv", out_pcv, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // fixed patterns for every size
    for (int es = 0; es < 4; es++) begin
      sweep_one(es, 16'h0000);
      sweep_one(es, 16'hFFFF);
      sweep_one(es, 16'hAAAA);
      sweep_one(es, 16'h5555);
    end
    // bytes: random select patterns
    for (int r = 0; r < 300; r++) sweep_one(0, 16'($urandom));
    // larger elements: every select pattern
    for (int es = 1; es < 4; es++) begin
      for (int pat = 0; pat < (1 << (16 >> es)); pat++) sweep_one(es, 16'(pat));
    end

    // R9 hold while idle, after a legal result
    txn(build_mask(1, 16'h0093, '0), 1, 1);
    last = ref_pcv(build_mask(1, 16'h0093, '0), 1, 1);
    in_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      in_mask = rnd128(); in_mode = 3'(4 + c); in_esize = 2'(c);
      @(negedge clk);
      chk("R9 idle out_valid low", {127'b0, out_valid}, '0);
      chk("R9 idle pcv held", out_pcv, last);
      chk("R9 idle illegal held", {127'b0, out_illegal}, '0);
    end
    // R8 then idle: flag and zero vector held
    txn(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 0, 7);
    in_valid = 1'b0; in_mode = 3'd0;
    @(negedge clk);
    chk("R8 R9 idle illegal held", {127'b0, out_illegal}, 128'd1);
    chk("R8 R9 idle zero held", out_pcv, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule